// File: doc/BRIEF.md
# Extended-Precision Round-to-Integer Unit

This unit takes one 80-bit extended-precision floating-point operand and returns a value in the same format. The operand has a sign bit at bit 79, a 15-bit biased exponent in bits 78:64, and a 64-bit significand with an explicit integer bit in bits 63:0. The main operation rounds the operand to an integral value. A 2-bit rounding-control input selects the direction. Two lighter operations touch only the sign bit: absolute value and negate. Every result comes with four exception flags: invalid, stack fault, denormal and precision.

The caller also supplies an empty tag for the operand. An empty operand is a stack underflow. It produces the indefinite NaN and raises both invalid and stack fault, whatever operation was selected.

Rounding works in place on the significand. Infinities and NaNs pass through untouched. Values whose unbiased exponent is 63 or more are already integral and also pass through. The unit accepts one operand per cycle while `in_ready` is high. Each accepted operand produces exactly one single-cycle `out_valid` pulse, and results leave in acceptance order.

Top module: `fxr_unit`

## Requirements
- R1: While reset is high, `in_ready` and `out_valid` are low. In the first cycle after reset is released, `in_ready` is high, and it stays high from then on.
- R2: An operand accepted at a clock edge (`in_valid` and `in_ready` both high) gives an `out_valid` pulse one cycle long, starting after the second following edge. Operands may be accepted on back-to-back cycles.
- R3: Rounding control 00 rounds to the nearest integer, with exact ties going to the even integer (2.5 gives 2.0, 0.5 gives +0). Operation code 00 selects rounding, and so does the unused code 11.
- R4: Rounding control 01 rounds toward minus infinity, 10 toward plus infinity, and 11 toward zero.
- R5: The precision flag is raised exactly when a rounding result differs from its finite, non-empty input. An integral input gives the same value back with no flags.
- R6: A nonzero magnitude below 1 rounds to a zero or to 1.0, according to the mode, and the result keeps the input sign (-0.3 to nearest gives -0).
- R7: When rounding up carries out of the significand, the result is significand 0x8000_0000_0000_0000 and the exponent is incremented by one.
- R8: Inputs with a biased exponent of 16446 or more (unbiased 63 or more, bias 16383) are returned unchanged with no flags. Zeros are also returned unchanged with no flags.
- R9: When rounding, an input with an all-ones exponent (an infinity or a NaN) is returned bit for bit with no flags.
- R10: When rounding, a denormal input (exponent zero, significand nonzero) raises the denormal flag. It is rounded as a magnitude below 1, so the precision flag is also raised.
- R11: An empty operand gives the indefinite NaN (sign 1, exponent all ones, significand 0xC000_0000_0000_0000). It raises invalid and stack fault, with denormal and precision low, for every operation code. Invalid and stack fault are never raised otherwise.
- R12: Operation code 01 (absolute value) clears bit 79 and code 10 (negate) inverts it. Both leave bits 78:0 unchanged and raise no flag, even for NaN and denormal inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can accept an operand this cycle |
| in_operand | input | 80 | Extended-precision operand |
| in_empty | input | 1 | Operand register is tagged empty |
| in_op | input | 2 | 00 round, 01 absolute value, 10 negate, 11 round |
| in_rc | input | 2 | 00 nearest even, 01 down, 10 up, 11 toward zero |
| out_valid | output | 1 | Result valid pulse |
| out_result | output | 80 | Result value |
| out_invalid | output | 1 | Invalid-operation flag |
| out_stack_fault | output | 1 | Stack-fault flag |
| out_denormal | output | 1 | Denormal-operand flag |
| out_precision | output | 1 | Inexact-result flag |

## Verification
Two functions can meet on the same operand: empty-operand handling, and either the special-value pass-through or a sign operation. This happens when the empty tag arrives together with a NaN payload, or together with an absolute-value or negate request. The bench provokes it by sending such operands back to back with ordinary roundings. It judges the outcome by comparing each popped result with the indefinite NaN and with invalid and stack fault both set. A second overlap is timing: a new operand is accepted in the same cycle that an earlier result is presented. Streams with no gaps exercise this, and every cycle's `out_valid` is compared with a bench-side two-stage delay of acceptances.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

  // Operation codes; code 2'b11 is decoded as rounding.
  typedef enum logic [1:0] {
    OP_RND = 2'b00,
    OP_ABS = 2'b01,
    OP_NEG = 2'b10,
    OP_RSV = 2'b11
  } op_e;

  // Rounding-control codes.
  localparam logic [1:0] RC_NEAR = 2'b00;
  localparam logic [1:0] RC_DOWN = 2'b01;
  localparam logic [1:0] RC_UP   = 2'b10;
  localparam logic [1:0] RC_ZERO = 2'b11;

  typedef struct packed {
    logic empty;    // operand tagged empty
    logic special;  // exponent all ones: infinity or NaN
    logic zero;     // exponent and significand zero
    logic denorm;   // exponent zero, significand nonzero
    logic big;      // already integral by exponent alone
  } cls_t;

endpackage

// File: rtl/fxr_classify.sv
module fxr_classify
  import fxr_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W+MAN_W:0] operand,
  input  logic                 empty,
  output cls_t                 cls
);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int BIG_EXP = BIAS + MAN_W - 1;

  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] sig;

  assign expo = operand[EXP_W+MAN_W-1:MAN_W];
  assign sig  = operand[MAN_W-1:0];

  always_comb begin
    cls.empty   = empty;
    cls.special = &expo;
    cls.zero    = (expo == '0) && (sig == '0);
    cls.denorm  = (expo == '0) && (sig != '0);
    cls.big     = !(&expo) && (expo >= EXP_W'(BIG_EXP));
  end
endmodule

// File: rtl/fxr_round.sv
module fxr_round
  import fxr_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic             sign,
  input  logic [EXP_W-1:0] expo,
  input  logic [MAN_W-1:0] sig,
  input  logic [1:0]       rc,
  output logic [EXP_W-1:0] r_expo,
  output logic [MAN_W-1:0] r_sig,
  output logic             inexact
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int SH_W = $clog2(MAN_W) + 1;

  logic             below_one;
  logic [EXP_W-1:0] ue;
  logic [SH_W-1:0]  fbits;
  logic [MAN_W-1:0] fmask, hmask, sh1;
  logic [MAN_W:0]   step, sum;
  logic             rb, st, lsb, up;

  assign below_one = expo < EXP_W'(BIAS);
  assign ue        = expo - EXP_W'(BIAS);
  assign fbits     = SH_W'(MAN_W - 1) - ue[SH_W-1:0];
  assign fmask     = ~({MAN_W{1'b1}} << fbits);
  assign hmask     = fmask >> 1;
  assign sh1       = sig >> (fbits - 1'b1);
  assign step      = (MAN_W+1)'(1) << fbits;

  always_comb begin
    if (below_one) begin
      rb  = (expo == EXP_W'(BIAS - 1)) && sig[MAN_W-1];
      st  = (expo == EXP_W'(BIAS - 1)) ? |sig[MAN_W-2:0] : |sig;
      lsb = 1'b0;
    end else begin
      rb  = sh1[0];
      st  = |(sig & hmask);
      lsb = sh1[1];
    end
    inexact = rb | st;
    unique case (rc)
      RC_NEAR: up = rb & (st | lsb);
      RC_DOWN: up = inexact & sign;
      RC_UP:   up = inexact & ~sign;
      default: up = 1'b0;
    endcase
    sum = {1'b0, sig & ~fmask} + (up ? step : '0);

    r_expo = expo;
    r_sig  = sig;
    if (inexact) begin
      if (below_one) begin
        r_expo = up ? EXP_W'(BIAS) : '0;
        r_sig  = up ? {1'b1, {(MAN_W-1){1'b0}}} : '0;
      end else if (sum[MAN_W]) begin
        r_expo = expo + 1'b1;
        r_sig  = {1'b1, {(MAN_W-1){1'b0}}};
      end else begin
        r_sig  = sum[MAN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/fxr_unit.sv
module fxr_unit
  import fxr_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [EXP_W+MAN_W:0] in_operand,
  input  logic                 in_empty,
  input  logic [1:0]           in_op,
  input  logic [1:0]           in_rc,
  output logic                 out_valid,
  output logic [EXP_W+MAN_W:0] out_result,
  output logic                 out_invalid,
  output logic                 out_stack_fault,
  output logic                 out_denormal,
  output logic                 out_precision
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] INDEF = {1'b1, {EXP_W{1'b1}}, 2'b11, {(MAN_W-2){1'b0}}};

  // Stage 1: captured operand and its class.
  cls_t            cls_d, s1_cls;
  logic            s1_vld;
  logic [1:0]      s1_op, s1_rc;
  logic [W-1:0]    s1_opd;

  fxr_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
    .operand(in_operand),
    .empty  (in_empty),
    .cls    (cls_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready <= 1'b0;
      s1_vld   <= 1'b0;
      s1_op    <= '0;
      s1_rc    <= '0;
      s1_opd   <= '0;
      s1_cls   <= '0;
    end else begin
      in_ready <= 1'b1;
      s1_vld   <= in_valid & in_ready;
      if (in_valid & in_ready) begin
        s1_op  <= in_op;
        s1_rc  <= in_rc;
        s1_opd <= in_operand;
        s1_cls <= cls_d;
      end
    end
  end

  // Stage 2: rounding and result selection.
  logic [EXP_W-1:0] r_expo;
  logic [MAN_W-1:0] r_sig;
  logic             r_inexact;

  fxr_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rnd (
    .sign   (s1_opd[W-1]),
    .expo   (s1_opd[W-2:MAN_W]),
    .sig    (s1_opd[MAN_W-1:0]),
    .rc     (s1_rc),
    .r_expo (r_expo),
    .r_sig  (r_sig),
    .inexact(r_inexact)
  );

  logic [W-1:0] nx_res;
  logic         nx_inv, nx_sf, nx_den, nx_prc;

  always_comb begin
    nx_res = s1_opd;
    nx_inv = 1'b0;
    nx_sf  = 1'b0;
    nx_den = 1'b0;
    nx_prc = 1'b0;
    if (s1_cls.empty) begin
      nx_res = INDEF;
      nx_inv = 1'b1;
      nx_sf  = 1'b1;
    end else begin
      unique case (s1_op)
        OP_ABS: nx_res[W-1] = 1'b0;
        OP_NEG: nx_res[W-1] = ~s1_opd[W-1];
        default: begin
          if (!(s1_cls.special || s1_cls.big || s1_cls.zero)) begin
            nx_res = {s1_opd[W-1], r_expo, r_sig};
            nx_prc = r_inexact;
            nx_den = s1_cls.denorm;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      out_result      <= '0;
      out_invalid     <= 1'b0;
      out_stack_fault <= 1'b0;
      out_denormal    <= 1'b0;
      out_precision   <= 1'b0;
    end else begin
      out_valid <= s1_vld;
      if (s1_vld) begin
        out_result      <= nx_res;
        out_invalid     <= nx_inv;
        out_stack_fault <= nx_sf;
        out_denormal    <= nx_den;
        out_precision   <= nx_prc;
      end
    end
  end
endmodule

// File: rtl/fxr_unit_chk.sv
module fxr_unit_chk #(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [EXP_W+MAN_W:0] in_operand,
  input logic                 in_empty,
  input logic [1:0]           in_op,
  input logic                 out_valid,
  input logic [EXP_W+MAN_W:0] out_result,
  input logic                 out_invalid,
  input logic                 out_stack_fault,
  input logic                 out_denormal,
  input logic                 out_precision
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] INDEF = {1'b1, {EXP_W{1'b1}}, 2'b11, {(MAN_W-2){1'b0}}};

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!in_ready && !out_valid)); // R1

  AST_VALID_HAS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready, 2)); // R2

  AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_ready, 2) && !$past(rst, 1) |-> out_valid); // R2

  AST_EMPTY_INDEF: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(in_empty, 2) |->
      (out_result == INDEF) && out_invalid && out_stack_fault && !out_precision); // R11

  AST_FAULT_PAIR: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_invalid == out_stack_fault)); // R11

  AST_SIGN_OPS_QUIET: assert property (@(posedge clk) disable iff (rst)
    out_valid && !$past(in_empty, 2) && ($past(in_op, 2) inside {2'b01, 2'b10}) |->
      !out_invalid && !out_denormal && !out_precision &&
      (out_result[W-2:0] == $past(in_operand[W-2:0], 2))); // R12

  AST_SPECIAL_PASS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !$past(in_empty, 2) && ($past(in_op, 2) inside {2'b00, 2'b11}) &&
      (&$past(in_operand[W-2:MAN_W], 2)) |->
      (out_result == $past(in_operand, 2)) && !out_precision && !out_denormal); // R9
endmodule

bind fxr_unit fxr_unit_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .in_operand     (in_operand),
  .in_empty       (in_empty),
  .in_op          (in_op),
  .out_valid      (out_valid),
  .out_result     (out_result),
  .out_invalid    (out_invalid),
  .out_stack_fault(out_stack_fault),
  .out_denormal   (out_denormal),
  .out_precision  (out_precision)
);

// File: tb/fxr_unit_test.sv
module fxr_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [79:0] in_operand = '0;
  logic        in_empty = 1'b0;
  logic [1:0]  in_op = '0;
  logic [1:0]  in_rc = '0;
  logic        out_valid;
  logic [79:0] out_result;
  logic        out_invalid, out_stack_fault, out_denormal, out_precision;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fxr_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_empty(in_empty), .in_op(in_op), .in_rc(in_rc),
    .out_valid(out_valid), .out_result(out_result), .out_invalid(out_invalid),
    .out_stack_fault(out_stack_fault), .out_denormal(out_denormal),
    .out_precision(out_precision)
  );

  typedef struct {
    logic [79:0] res;
    logic [3:0]  flg;  // {invalid, stack fault, denormal, precision}
    string       tag;
  } exp_t;
  exp_t sb[$];

  function automatic logic [79:0] fp(input logic s, input logic [14:0] e, input logic [63:0] m);
    return {s, e, m};
  endfunction

  localparam logic [63:0] M1  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] M15 = 64'hC000_0000_0000_0000;
  localparam logic [63:0] M03 = 64'h9999_9999_9999_999A;
  localparam logic [79:0] INDEF = {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000};

  task automatic send(input logic [1:0] op, input logic [1:0] rc, input logic emp,
                      input logic [79:0] opd, input logic [79:0] er, input logic [3:0] ef,
                      input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_rc = rc; in_empty = emp; in_operand = opd;
    sb.push_back('{er, ef, tag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_empty = 1'b0; in_operand = '0;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Independent latency model: acceptances delayed by two edges.
  logic [1:0] acc = '0;
  always @(posedge clk) acc <= rst ? 2'b00 : {acc[0], in_valid & in_ready};

  // Monitor: scoreboard compare and latency compare.
  always @(negedge clk) begin
    if (!rst && (out_valid || acc[1]))
      chk(out_valid == acc[1], "R2 valid timing", 96'(out_valid), 96'(acc[1]));
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2 unexpected result", 96'(out_result), 96'(0));
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk((out_result == e.res) &&
            ({out_invalid, out_stack_fault, out_denormal, out_precision} == e.flg),
            e.tag,
            {12'h0, out_invalid, out_stack_fault, out_denormal, out_precision, out_result},
            {12'h0, e.flg, e.res});
      end
    end
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(!in_ready && !out_valid, "R1 reset state", 96'({in_ready, out_valid}), 96'(0));
    end
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", 96'(in_ready), 96'(1));

    // Nearest-even and carry cases, back to back.
    send(2'b00, 2'b00, 0, fp(0, 15'h4000, 64'hA000_0000_0000_0000), fp(0, 15'h4000, M1), 4'b0001, "R3 2.5 nearest");
    send(2'b00, 2'b00, 0, fp(0, 15'h4000, 64'hE000_0000_0000_0000), fp(0, 15'h4001, M1), 4'b0001, "R7 3.5 nearest carry");
    send(2'b00, 2'b00, 0, fp(0, 15'h4000, 64'hB000_0000_0000_0000), fp(0, 15'h4000, M15), 4'b0001, "R3 2.75 nearest");
    send(2'b11, 2'b00, 0, fp(0, 15'h3FFE, M1), fp(0, 15'h0, 64'h0), 4'b0001, "R3 0.5 tie to even, op 11");
    send(2'b00, 2'b00, 0, fp(0, 15'h3FFF, M15), fp(0, 15'h4000, M1), 4'b0001, "R7 1.5 nearest carry");
    idle(2);
    // Directed modes.
    send(2'b00, 2'b01, 0, fp(0, 15'h4000, 64'hA000_0000_0000_0000), fp(0, 15'h4000, M1), 4'b0001, "R4 2.5 down");
    send(2'b00, 2'b10, 0, fp(0, 15'h4000, 64'hA000_0000_0000_0000), fp(0, 15'h4000, M15), 4'b0001, "R4 2.5 up");
    send(2'b00, 2'b11, 0, fp(0, 15'h4000, 64'hA000_0000_0000_0000), fp(0, 15'h4000, M1), 4'b0001, "R4 2.5 zero");
    send(2'b00, 2'b01, 0, fp(1, 15'h4000, 64'hA000_0000_0000_0000), fp(1, 15'h4000, M15), 4'b0001, "R4 -2.5 down");
    send(2'b00, 2'b10, 0, fp(1, 15'h4000, 64'hA000_0000_0000_0000), fp(1, 15'h4000, M1), 4'b0001, "R4 -2.5 up");
    send(2'b00, 2'b11, 0, fp(1, 15'h4000, 64'hA000_0000_0000_0000), fp(1, 15'h4000, M1), 4'b0001, "R4 -2.5 zero");
    send(2'b00, 2'b00, 0, fp(0, 15'h4000, M15), fp(0, 15'h4000, M15), 4'b0000, "R5 exact 3.0");
    idle(1);
    // Magnitudes below one.
    send(2'b00, 2'b00, 0, fp(0, 15'h3FFD, M03), fp(0, 15'h0, 64'h0), 4'b0001, "R6 0.3 nearest");
    send(2'b00, 2'b00, 0, fp(1, 15'h3FFD, M03), fp(1, 15'h0, 64'h0), 4'b0001, "R6 -0.3 nearest");
    send(2'b00, 2'b10, 0, fp(0, 15'h3FFD, M03), fp(0, 15'h3FFF, M1), 4'b0001, "R6 0.3 up");
    send(2'b00, 2'b01, 0, fp(1, 15'h3FFD, M03), fp(1, 15'h3FFF, M1), 4'b0001, "R6 -0.3 down");
    send(2'b00, 2'b10, 0, fp(1, 15'h3FFD, M03), fp(1, 15'h0, 64'h0), 4'b0001, "R6 -0.3 up");
    send(2'b00, 2'b00, 0, fp(0, 15'h3FFE, M15), fp(0, 15'h3FFF, M1), 4'b0001, "R6 0.75 nearest");
    // Largest in-range exponent and the integral limit.
    send(2'b00, 2'b00, 0, fp(0, 15'h403D, 64'h8000_0000_0000_0001), fp(0, 15'h403D, M1), 4'b0001, "R3 e62 tie down");
    send(2'b00, 2'b00, 0, fp(0, 15'h403D, 64'h8000_0000_0000_0003), fp(0, 15'h403D, 64'h8000_0000_0000_0004), 4'b0001, "R3 e62 tie up");
    send(2'b00, 2'b00, 0, fp(0, 15'h403D, 64'hFFFF_FFFF_FFFF_FFFF), fp(0, 15'h403E, M1), 4'b0001, "R7 e62 carry");
    send(2'b00, 2'b10, 0, fp(0, 15'h403E, 64'h8000_0000_0000_0001), fp(0, 15'h403E, 64'h8000_0000_0000_0001), 4'b0000, "R8 e63 unchanged");
    send(2'b00, 2'b11, 0, fp(1, 15'h0, 64'h0), fp(1, 15'h0, 64'h0), 4'b0000, "R8 negative zero");
    // Specials and denormals.
    send(2'b00, 2'b10, 0, fp(1, 15'h7FFF, M1), fp(1, 15'h7FFF, M1), 4'b0000, "R9 -inf");
    send(2'b00, 2'b00, 0, fp(0, 15'h7FFF, 64'hC000_0000_0000_1234), fp(0, 15'h7FFF, 64'hC000_0000_0000_1234), 4'b0000, "R9 NaN");
    send(2'b00, 2'b10, 0, fp(0, 15'h0, 64'h10), fp(0, 15'h3FFF, M1), 4'b0011, "R10 denormal up");
    send(2'b00, 2'b00, 0, fp(0, 15'h0, 64'h10), fp(0, 15'h0, 64'h0), 4'b0011, "R10 denormal nearest");
    send(2'b00, 2'b01, 0, fp(1, 15'h0, 64'h10), fp(1, 15'h3FFF, M1), 4'b0011, "R10 -denormal down");
    // Empty operand on every operation, mixed with specials.
    send(2'b00, 2'b00, 1, fp(0, 15'h7FFF, 64'hC000_0000_0000_1234), INDEF, 4'b1100, "R11 empty NaN round");
    send(2'b01, 2'b00, 1, fp(1, 15'h4000, 64'hA000_0000_0000_0000), INDEF, 4'b1100, "R11 empty abs");
    send(2'b10, 2'b10, 1, fp(0, 15'h7FFF, M1), INDEF, 4'b1100, "R11 empty neg inf");
    // Sign-only operations.
    send(2'b01, 2'b10, 0, fp(1, 15'h4000, 64'hA000_0000_0000_0000), fp(0, 15'h4000, 64'hA000_0000_0000_0000), 4'b0000, "R12 abs -2.5");
    send(2'b10, 2'b00, 0, fp(0, 15'h3FFD, M03), fp(1, 15'h3FFD, M03), 4'b0000, "R12 neg 0.3");
    send(2'b10, 2'b00, 0, fp(0, 15'h7FFF, 64'hC000_0000_0000_1234), fp(1, 15'h7FFF, 64'hC000_0000_0000_1234), 4'b0000, "R12 neg NaN");
    send(2'b01, 2'b00, 0, fp(1, 15'h0, 64'h10), fp(0, 15'h0, 64'h10), 4'b0000, "R12 abs denormal");
    idle(4);

    chk(sb.size() == 0, "R2 results outstanding", 96'(sb.size()), 96'(0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R2 watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule